// File: doc/BRIEF.md
# Target Power and Bus Programming Sequencer

This block walks a target device through one full configuration cycle under the control of a slow tick. It turns the target's supply on and off and releases or pulls low the idle level of its two serial bus lines. It opens windows in which an external bus master may run its transactions, and it enforces the minimum quiet and settle times between those steps. The bus transactions themselves happen outside the block. The master only reports the end of each window with a one-cycle `comm_done` strobe.

The cycle runs in this order:

1. Supply on.
2. Wait for the undervoltage-OK indication.
3. Release the bus.
4. Settle.
5. Programming window.
6. Quiet erase and write wait.
7. Lock window.
8. Bus pulled low, then supply off.
9. Off hold.
10. Re-power, with the same raise and settle rules as before.
11. Readback window.
12. Bus low, then supply off, then done.

A window that the master leaves open too long ends in an error path. That path also pulls the bus low before it removes the supply.

All durations are counted in ticks. A free-running divider makes one tick every `TICK_DIV` clock cycles. With the default value of 250000 at 250 MHz, one tick is 1 ms. The default minimums are a 60-tick combined settle, a 40-tick erase wait and a 10-tick off hold.

Top module: `prog_pwr_seq`

## Requirements
- R1: After reset, `sup_en`, `bus_rel`, `busy` and `done` are 0 and `phase` is 0.
- R2: A `start` pulse in phase 0, 14 or 16 moves the block to phase 1 (supply on, bus low, `busy`=1). A `start` pulse in any other phase has no effect.
- R3: The bus is released (phase 3) only after more than `RAISE_TICKS` ticks have passed since `uv_ok` was seen in phase 1, so at least `RAISE_TICKS*TICK_DIV` cycles later.
- R4: The programming window (phase 4) opens only after more than `SETTLE_TICKS` ticks counted from that same `uv_ok` point. The time before the bus release and the time after it are counted together.
- R5: Windows (phases 4, 6 and 12) stay open until `comm_done` is seen. A `comm_done` pulse outside a window is ignored.
- R6: After the programming window closes, phase 5 keeps the bus released with no window for at least `ERASE_TICKS*TICK_DIV` cycles. The lock window (phase 6) follows.
- R7: When the lock window closes, phase 7 pulls the bus low while the supply is still on. The supply never falls in the same cycle as the bus, and the bus is never released while the supply is off.
- R8: Phase 8 holds the supply and the bus low for at least `OFF_TICKS*TICK_DIV` cycles. Phase 9 then re-applies the supply.
- R9: After re-power, phases 10 and 11 apply the same raise and settle minimums before the readback window (phase 12) opens.
- R10: When the readback window closes, phase 13 pulls the bus low with the supply on. Phase 14 follows with the supply off, `done`=1 and `busy`=0.
- R11: If a window has seen more than `TIMEOUT_TICKS` ticks (when this parameter is non-zero), the block goes to phase 15 (bus low, supply on) and then to phase 16 (all off, `busy`=0, `done`=0).
- R12: Phase encoding:

  | Code | Phase |
  |---|---|
  | 0 | idle |
  | 1 | uv-wait |
  | 2 | raise |
  | 3 | settle |
  | 4 | program window |
  | 5 | erase wait |
  | 6 | lock window |
  | 7 | bus drop |
  | 8 | off hold |
  | 9 | re-power uv-wait |
  | 10 | re-raise |
  | 11 | re-settle |
  | 12 | readback window |
  | 13 | final bus drop |
  | 14 | done |
  | 15 | error bus drop |
  | 16 | error |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a configuration cycle |
| uv_ok | input | 1 | Target supply is above its undervoltage threshold |
| comm_done | input | 1 | Strobe from the bus master that ends the current window |
| sup_en | output | 1 | Target supply enable |
| bus_rel | output | 1 | 1 releases both bus lines high, 0 pulls them low |
| phase | output | 5 | Current step code (R12) |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | The cycle completed |

## Verification
The assertions check the following on every cycle:
- the bus never stays released without supply, and is released only after the supply came up;
- the supply falls only after the bus was already low;
- the erase-wait and off-hold phases last at least their minimum number of cycles;
- a window cannot close without the done strobe;
- the flags in the done and error phases are correct.

Only the bench scenarios can show the following:
- that the combined settle time is counted from the undervoltage point;
- that stray done strobes and start pulses are ignored;
- that re-power repeats the settle rule;
- that the timeout path is taken.

The bench compares each of these against its own tick-level model on every clock.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

    localparam int PHASE_W = 5;

    typedef enum logic [PHASE_W-1:0] {
        PH_IDLE      = 5'd0,
        PH_UV_WAIT   = 5'd1,
        PH_RAISE     = 5'd2,
        PH_SETTLE    = 5'd3,
        PH_PROG      = 5'd4,
        PH_ERASE     = 5'd5,
        PH_LOCK      = 5'd6,
        PH_DROP      = 5'd7,
        PH_OFF       = 5'd8,
        PH_RE_UV     = 5'd9,
        PH_RE_RAISE  = 5'd10,
        PH_RE_SETTLE = 5'd11,
        PH_READ      = 5'd12,
        PH_FIN_DROP  = 5'd13,
        PH_DONE      = 5'd14,
        PH_ERR_DROP  = 5'd15,
        PH_ERR       = 5'd16
    } phase_e;

    typedef struct packed {
        logic sup;
        logic bus;
        logic busy;
        logic done;
    } drive_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic drive_t phase_drive(input phase_e p);
        drive_t d;
        d.sup  = !(p inside {PH_IDLE, PH_OFF, PH_DONE, PH_ERR});
        d.bus  = (p inside {PH_SETTLE, PH_PROG, PH_ERASE, PH_LOCK,
                            PH_RE_SETTLE, PH_READ});
        d.busy = !(p inside {PH_IDLE, PH_DONE, PH_ERR});
        d.done = (p == PH_DONE);
        return d;
    endfunction

    // Interval counter keeps running from raise into settle (combined minimum)
    function automatic logic keeps_count(input phase_e cur, input phase_e nxt);
        return (cur == PH_RAISE && nxt == PH_SETTLE) ||
               (cur == PH_RE_RAISE && nxt == PH_RE_SETTLE);
    endfunction

endpackage

// File: rtl/prog_tick_gen.sv
module prog_tick_gen #(
    parameter int TICK_DIV = 250000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (TICK_DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(TICK_DIV);
            logic [DW-1:0] div_q;
            assign tick = (div_q == DW'(TICK_DIV - 1));
            always_ff @(posedge clk) begin
                if (rst)       div_q <= '0;
                else if (tick) div_q <= '0;
                else           div_q <= div_q + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/prog_ivl_cnt.sv
module prog_ivl_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);
    logic sat;
    assign sat = &cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (clr)          cnt <= '0;
        else if (tick && !sat) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/prog_seq_fsm.sv
module prog_seq_fsm
    import prog_seq_pkg::*;
#(
    parameter int CNT_W         = 8,
    parameter int RAISE_TICKS   = 5,
    parameter int SETTLE_TICKS  = 60,
    parameter int ERASE_TICKS   = 40,
    parameter int OFF_TICKS     = 10,
    parameter int GAP_TICKS     = 1,
    parameter int TIMEOUT_TICKS = 2000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             uv_ok,
    input  logic             comm_done,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clr,
    output phase_e           phase_q
);
    localparam logic TMO_EN = (TIMEOUT_TICKS > 0);

    phase_e nxt;
    logic   over_raise, over_settle, over_erase, over_off, over_gap, tmo;

    // Strictly greater: the partial tick at entry is never counted
    assign over_raise  = cnt > CNT_W'(RAISE_TICKS);
    assign over_settle = cnt > CNT_W'(SETTLE_TICKS);
    assign over_erase  = cnt > CNT_W'(ERASE_TICKS);
    assign over_off    = cnt > CNT_W'(OFF_TICKS);
    assign over_gap    = cnt > CNT_W'(GAP_TICKS);
    assign tmo         = TMO_EN && (cnt > CNT_W'(TIMEOUT_TICKS));

    always_comb begin
        nxt = phase_q;
        unique case (phase_q)
            PH_IDLE, PH_DONE, PH_ERR: if (start) nxt = PH_UV_WAIT;
            PH_UV_WAIT:   if (uv_ok)       nxt = PH_RAISE;
            PH_RAISE:     if (over_raise)  nxt = PH_SETTLE;
            PH_SETTLE:    if (over_settle) nxt = PH_PROG;
            PH_PROG: begin
                if (comm_done) nxt = PH_ERASE;
                else if (tmo)  nxt = PH_ERR_DROP;
            end
            PH_ERASE:     if (over_erase)  nxt = PH_LOCK;
            PH_LOCK: begin
                if (comm_done) nxt = PH_DROP;
                else if (tmo)  nxt = PH_ERR_DROP;
            end
            PH_DROP:      if (over_gap)    nxt = PH_OFF;
            PH_OFF:       if (over_off)    nxt = PH_RE_UV;
            PH_RE_UV:     if (uv_ok)       nxt = PH_RE_RAISE;
            PH_RE_RAISE:  if (over_raise)  nxt = PH_RE_SETTLE;
            PH_RE_SETTLE: if (over_settle) nxt = PH_READ;
            PH_READ: begin
                if (comm_done) nxt = PH_FIN_DROP;
                else if (tmo)  nxt = PH_ERR_DROP;
            end
            PH_FIN_DROP:  if (over_gap)    nxt = PH_DONE;
            PH_ERR_DROP:  if (over_gap)    nxt = PH_ERR;
            default:                       nxt = PH_IDLE;
        endcase
    end

    assign cnt_clr = (nxt != phase_q) && !keeps_count(phase_q, nxt);

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= nxt;
    end
endmodule

// File: rtl/prog_pwr_seq.sv
module prog_pwr_seq
    import prog_seq_pkg::*;
#(
    parameter int TICK_DIV      = 250000,
    parameter int RAISE_TICKS   = 5,
    parameter int SETTLE_TICKS  = 60,
    parameter int ERASE_TICKS   = 40,
    parameter int OFF_TICKS     = 10,
    parameter int GAP_TICKS     = 1,
    parameter int TIMEOUT_TICKS = 2000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               uv_ok,
    input  logic               comm_done,
    output logic               sup_en,
    output logic               bus_rel,
    output logic [PHASE_W-1:0] phase,
    output logic               busy,
    output logic               done
);
    localparam int MAX_T = max_of(max_of(max_of(RAISE_TICKS, SETTLE_TICKS),
                                         max_of(ERASE_TICKS, OFF_TICKS)),
                                  max_of(GAP_TICKS, TIMEOUT_TICKS));
    localparam int CNT_W = $clog2(MAX_T + 2);

    logic             tick;
    logic             cnt_clr;
    logic [CNT_W-1:0] cnt;
    phase_e           ph;
    drive_t           drv;

    prog_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    prog_ivl_cnt #(.CNT_W(CNT_W)) cnt_i (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .tick(tick),
        .cnt (cnt)
    );

    prog_seq_fsm #(
        .CNT_W        (CNT_W),
        .RAISE_TICKS  (RAISE_TICKS),
        .SETTLE_TICKS (SETTLE_TICKS),
        .ERASE_TICKS  (ERASE_TICKS),
        .OFF_TICKS    (OFF_TICKS),
        .GAP_TICKS    (GAP_TICKS),
        .TIMEOUT_TICKS(TIMEOUT_TICKS)
    ) fsm_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .uv_ok    (uv_ok),
        .comm_done(comm_done),
        .cnt      (cnt),
        .cnt_clr  (cnt_clr),
        .phase_q  (ph)
    );

    assign drv     = phase_drive(ph);
    assign sup_en  = drv.sup;
    assign bus_rel = drv.bus;
    assign busy    = drv.busy;
    assign done    = drv.done;
    assign phase   = ph;
endmodule

// File: rtl/prog_pwr_seq_chk.sv
module prog_pwr_seq_chk
    import prog_seq_pkg::*;
#(
    parameter int TICK_DIV    = 250000,
    parameter int ERASE_TICKS = 40,
    parameter int OFF_TICKS   = 10
) (
    input logic               clk,
    input logic               rst,
    input logic               comm_done,
    input logic               sup_en,
    input logic               bus_rel,
    input logic [PHASE_W-1:0] phase,
    input logic               busy,
    input logic               done
);
    logic [PHASE_W-1:0] prev_ph;
    logic [31:0]        stay;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ph <= '0;
            stay    <= '0;
        end else begin
            prev_ph <= phase;
            stay    <= (phase == prev_ph) ? stay + 32'd1 : 32'd1;
        end
    end

    p_bus_needs_sup_r7: assert property (@(posedge clk) disable iff (rst)
        bus_rel |-> sup_en);
    p_sup_falls_after_bus_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(sup_en) |-> !$past(bus_rel));
    p_raise_after_sup_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_rel) |-> $past(sup_en));
    p_busy_entry_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (sup_en && !bus_rel && phase == PHASE_W'(PH_UV_WAIT)));
    p_window_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PHASE_W'(PH_PROG) && !comm_done) |=>
        (phase == PHASE_W'(PH_PROG) || phase == PHASE_W'(PH_ERR_DROP)));
    p_erase_min_r6: assert property (@(posedge clk) disable iff (rst)
        (phase != prev_ph && prev_ph == PHASE_W'(PH_ERASE)) |->
        (stay >= 32'(ERASE_TICKS * TICK_DIV)));
    p_off_min_r8: assert property (@(posedge clk) disable iff (rst)
        (phase != prev_ph && prev_ph == PHASE_W'(PH_OFF)) |->
        (stay >= 32'(OFF_TICKS * TICK_DIV)));
    p_off_low_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == PHASE_W'(PH_OFF)) |-> (!sup_en && !bus_rel));
    p_done_flags_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!sup_en && !bus_rel && !busy));
    p_err_flags_r11: assert property (@(posedge clk) disable iff (rst)
        (phase == PHASE_W'(PH_ERR)) |-> (!sup_en && !bus_rel && !busy && !done));
    p_phase_range_r12: assert property (@(posedge clk) disable iff (rst)
        phase <= PHASE_W'(PH_ERR));
endmodule

bind prog_pwr_seq prog_pwr_seq_chk #(
    .TICK_DIV   (TICK_DIV),
    .ERASE_TICKS(ERASE_TICKS),
    .OFF_TICKS  (OFF_TICKS)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .comm_done(comm_done),
    .sup_en   (sup_en),
    .bus_rel  (bus_rel),
    .phase    (phase),
    .busy     (busy),
    .done     (done)
);

// File: tb/prog_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module prog_pwr_seq_tb_top;
    localparam int DIV = 4, RT = 2, ST = 5, ET = 4, OT = 3, GT = 1, TO = 12;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, uv_ok = 1'b0, comm_done = 1'b0;
    logic sup_en, bus_rel, busy, done;
    logic [4:0] phase;

    int checks = 0, bad = 0, cyc = 0;
    bit model_on = 1'b0;

    always #2 clk = ~clk;

    prog_pwr_seq #(.TICK_DIV(DIV), .RAISE_TICKS(RT), .SETTLE_TICKS(ST),
                   .ERASE_TICKS(ET), .OFF_TICKS(OFF_T_FIX()), .GAP_TICKS(GT),
                   .TIMEOUT_TICKS(TO)) dut_i (
        .clk(clk), .rst(rst), .start(start), .uv_ok(uv_ok), .comm_done(comm_done),
        .sup_en(sup_en), .bus_rel(bus_rel), .phase(phase), .busy(busy), .done(done));

    function automatic int OFF_T_FIX();
        return OT;
    endfunction

    // ---------------- behavioural reference model ----------------
    int m_div = 0, m_cnt = 0, m_ph = 0;

    function automatic int m_next(int ph, int c, bit st, bit uv, bit cd);
        case (ph)
            0, 14, 16: return st ? 1 : ph;
            1:  return uv ? 2 : 1;
            2:  return (c > RT) ? 3 : 2;
            3:  return (c > ST) ? 4 : 3;
            4:  return cd ? 5 : ((c > TO) ? 15 : 4);
            5:  return (c > ET) ? 6 : 5;
            6:  return cd ? 7 : ((c > TO) ? 15 : 6);
            7:  return (c > GT) ? 8 : 7;
            8:  return (c > OT) ? 9 : 8;
            9:  return uv ? 10 : 9;
            10: return (c > RT) ? 11 : 10;
            11: return (c > ST) ? 12 : 11;
            12: return cd ? 13 : ((c > TO) ? 15 : 12);
            13: return (c > GT) ? 14 : 13;
            15: return (c > GT) ? 16 : 15;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            m_div = 0; m_cnt = 0; m_ph = 0;
        end else begin
            bit tk;
            int nx;
            tk = (m_div == DIV - 1);
            m_div = tk ? 0 : m_div + 1;
            nx = m_next(m_ph, m_cnt, start, uv_ok, comm_done);
            if (nx != m_ph && !(m_ph == 2 && nx == 3) && !(m_ph == 10 && nx == 11))
                m_cnt = 0;
            else if (tk)
                m_cnt = m_cnt + 1;
            m_ph = nx;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (model_on && !rst) begin
            bit e_sup, e_bus, e_busy, e_done;
            e_sup  = !(m_ph inside {0, 8, 14, 16});
            e_bus  = (m_ph inside {3, 4, 5, 6, 11, 12});
            e_busy = !(m_ph inside {0, 14, 16});
            e_done = (m_ph == 14);
            chk(int'(phase) == m_ph, "R12", "model phase", int'(phase), m_ph);
            chk(sup_en == e_sup, "R7", "model sup_en", sup_en, e_sup);
            chk(bus_rel == e_bus, "R3", "model bus_rel", bus_rel, e_bus);
            chk(busy == e_busy && done == e_done, "R10", "model busy/done",
                {busy, done}, {e_busy, e_done});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ph(input int p, input string req);
        int k = 0;
        while (int'(phase) != p && k < 2000) begin
            @(negedge clk);
            k++;
        end
        chk(int'(phase) == p, req, "reach phase", int'(phase), p);
    endtask

    task automatic pulse_start();
        start = 1'b1; step(1); start = 1'b0;
    endtask

    task automatic pulse_done();
        comm_done = 1'b1; step(1); comm_done = 1'b0;
    endtask

    initial begin
        #400000;
        bad++;
        checks++;
        $display("FAIL R12 watchdog expired act=%0d exp=0", cyc);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        int t0, t1;
        step(3);
        rst = 1'b0;
        model_on = 1'b1;
        step(1);
        // R1 reset state
        chk(!sup_en && !bus_rel && !busy && !done && phase == 5'd0, "R1",
            "reset outputs", {sup_en, bus_rel, busy, done, phase}, 0);

        // ---- normal cycle ----
        pulse_start();
        chk(phase == 5'd1 && sup_en && !bus_rel && busy, "R2", "start entry",
            int'(phase), 1);
        pulse_start();  // ignored while busy
        chk(phase == 5'd1, "R2", "start ignored while busy", int'(phase), 1);
        pulse_done();   // outside any window
        chk(phase == 5'd1, "R5", "done ignored outside window", int'(phase), 1);
        step(4);
        uv_ok = 1'b1;
        t0 = cyc;
        wait_ph(3, "R3");
        chk(cyc - t0 >= RT * DIV, "R3", "raise delay", cyc - t0, RT * DIV);
        wait_ph(4, "R4");
        chk(cyc - t0 >= ST * DIV, "R4", "combined settle", cyc - t0, ST * DIV);
        step(8);
        chk(phase == 5'd4, "R5", "window held open", int'(phase), 4);
        pulse_done();
        chk(phase == 5'd5 && bus_rel, "R6", "erase entry", int'(phase), 5);
        t1 = cyc;
        step(3);
        pulse_done();
        chk(phase == 5'd5, "R5", "done ignored in erase", int'(phase), 5);
        wait_ph(6, "R6");
        chk(cyc - t1 >= ET * DIV, "R6", "erase quiet length", cyc - t1, ET * DIV);
        step(2);
        pulse_done();
        chk(phase == 5'd7 && sup_en && !bus_rel, "R7", "bus low before supply",
            {sup_en, bus_rel}, 2);
        wait_ph(8, "R7");
        chk(!sup_en && !bus_rel, "R8", "off hold levels", {sup_en, bus_rel}, 0);
        t1 = cyc;
        uv_ok = 1'b0;
        wait_ph(9, "R8");
        chk(cyc - t1 >= OT * DIV && sup_en, "R8", "off hold length",
            cyc - t1, OT * DIV);
        step(3);
        uv_ok = 1'b1;
        t0 = cyc;
        wait_ph(11, "R9");
        chk(cyc - t0 >= RT * DIV, "R9", "re-raise delay", cyc - t0, RT * DIV);
        wait_ph(12, "R9");
        chk(cyc - t0 >= ST * DIV, "R9", "re-settle", cyc - t0, ST * DIV);
        pulse_done();
        chk(phase == 5'd13 && sup_en && !bus_rel, "R10", "final drop",
            {sup_en, bus_rel}, 2);
        wait_ph(14, "R10");
        chk(done && !busy && !sup_en, "R10", "done state", {done, busy, sup_en}, 4);

        // ---- timeout path ----
        pulse_start();
        wait_ph(4, "R11");
        t1 = cyc;
        wait_ph(15, "R11");
        chk(cyc - t1 >= TO * DIV, "R11", "timeout length", cyc - t1, TO * DIV);
        chk(sup_en && !bus_rel, "R11", "error bus drop", {sup_en, bus_rel}, 2);
        wait_ph(16, "R11");
        chk(!sup_en && !busy && !done, "R11", "error state", {sup_en, busy, done}, 0);

        // ---- fast cycle from error, done strobes at first window cycle ----
        pulse_start();
        wait_ph(4, "R12");
        pulse_done();
        wait_ph(6, "R12");
        pulse_done();
        wait_ph(12, "R12");
        pulse_done();
        wait_ph(14, "R12");
        chk(done, "R12", "second completion", done, 1);

        step(4);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule